// File: doc/BRIEF.md
# Dual-Master Interrupt Status Register

This block keeps the interrupt status byte of a device that two bus masters share, and drives the interrupt line that goes back to the local master. Six flags sit in the byte. Each flag has its own source and its own way of clearing.

- Three flags latch one-cycle event pulses and are cleared by reading the register:
  - the bus-recovery-done event,
  - the busy-at-switch sensor,
  - the bus-lost detector.
- Three flags follow a level and ignore reads:
  - the external active-low interrupt input,
  - the local test request,
  - the other master's test request.

The serial engine in front of the block gives it two strobes. `rd_start` marks the start of a read of this register. `scl_pulse` marks each clock pulse of that read. The read-clearable flags drop at the second pulse, in the middle of the transfer, and not when the transfer ends. A per-bit mask decides which flags may pull the active-low interrupt line.

Top module: `irq_status_reg`

## Requirements
- R1: After reset every bit of `status` is 0 and `irq_n` is 1.
- R2: `status[0]` is 1 in the cycle after a cycle in which `ext_irq_n` is 0, and 0 in the cycle after a cycle in which it is 1. A read has no effect on it.
- R3: A one-cycle pulse on `ev_recov_done` sets `status[1]` one cycle later, and the bit stays set until a read clears it.
- R4: A pulse on `ev_sensor` sets `status[2]` one cycle later, unless `recov_req` is 1 in that cycle. In that case the bit stays 0.
- R5: A pulse on `ev_bus_lost` sets `status[3]` one cycle later, and the bit stays set until a read clears it.
- R6: `scl_pulse` strobes are counted in the cycles after a `rd_start` strobe. Bits 3:1 clear in the cycle after the second counted pulse. The first pulse leaves them set. Pulses after the second do nothing until the next `rd_start`.
- R7: `status[4]` is 1 one cycle after `test_self` is 1, and 0 one cycle after `test_self` is 0. Reads do not change it.
- R8: `status[5]` is 1 one cycle after `test_other` is 1, and 0 one cycle after `test_other` is 0. Reads do not change it.
- R9: `irq_n` is 0 exactly when some bit i in 5:0 has `status[i]`=1 and `mask[i]`=0. Otherwise it is 1.
- R10: If a set event for bit 1, 2 or 3 arrives in the same cycle as the clearing pulse, that bit remains 1.
- R11: `status[7:6]` always read 0.
- R12: If `ext_irq_n` is still 0 after a read sequence and `mask[0]` is 0, then `irq_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_recov_done | input | 1 | Pulse: bus recovery/initialization finished |
| ev_sensor | input | 1 | Pulse: bus was busy when a channel switch happened |
| recov_req | input | 1 | Level: bus recovery requested; blocks the sensor flag |
| ev_bus_lost | input | 1 | Pulse: bus lost |
| ext_irq_n | input | 1 | External interrupt input, active low |
| test_self | input | 1 | Local test-interrupt control bit |
| test_other | input | 1 | Other master's test-interrupt control bit |
| mask | input | 6 | Per-bit interrupt mask, 1 = masked |
| rd_start | input | 1 | Strobe: a read of this register begins |
| scl_pulse | input | 1 | Strobe: one clock pulse of the read transfer |
| status | output | 8 | Status byte |
| irq_n | output | 1 | Interrupt to the local master, active low |

## Verification
On every cycle, the assertions check these behaviours:
- the three level-following flags track their sources one cycle late,
- the read clear lands,
- the sensor flag is blocked while recovery is requested,
- an unmasked test flag pulls the interrupt line.

Only the bench's scenarios can show the rest:
- the exact pulse count at which the read clear fires,
- that set wins over clear,
- the re-assertion after a read while the input is still low,
- the full mask-by-flag sweep of the interrupt line.

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int CLR_PULSE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_recov_done,
  input  logic       ev_sensor,
  input  logic       recov_req,
  input  logic       ev_bus_lost,
  input  logic       ext_irq_n,
  input  logic       test_self,
  input  logic       test_other,
  input  logic [5:0] mask,
  input  logic       rd_start,
  input  logic       scl_pulse,
  output logic [7:0] status,
  output logic       irq_n
);
  localparam int CW = $clog2(CLR_PULSE + 1);

  logic          rd_act;
  logic [CW-1:0] pcnt;
  logic          clr;
  logic          intin, businit, busok, buslost, mytest, nmytest;

  assign clr = rd_act && scl_pulse && !rd_start && (pcnt == CW'(CLR_PULSE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act <= 1'b0;
      pcnt   <= '0;
    end else if (rd_start) begin
      rd_act <= 1'b1;
      pcnt   <= '0;
    end else if (rd_act && scl_pulse) begin
      if (clr) rd_act <= 1'b0;
      else     pcnt   <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intin   <= 1'b0;
      businit <= 1'b0;
      busok   <= 1'b0;
      buslost <= 1'b0;
      mytest  <= 1'b0;
      nmytest <= 1'b0;
    end else begin
      intin   <= !ext_irq_n;
      businit <= ev_recov_done | (businit & !clr);
      busok   <= (ev_sensor & !recov_req) | (busok & !clr);
      buslost <= ev_bus_lost | (buslost & !clr);
      mytest  <= test_self;
      nmytest <= test_other;
    end
  end

  assign status = {2'b00, nmytest, mytest, buslost, busok, businit, intin};
  assign irq_n  = ~|(status[5:0] & ~mask);

  // R2
  intin_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> status[0] == !$past(ext_irq_n));
  // R7
  mytest_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !test_self) |=> !status[4]);
  // R8
  nmytest_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !test_other) |=> !status[5]);
  // R4
  busok_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && recov_req && !status[2]) |=> !status[2]);
  // R6
  lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && clr && !ev_bus_lost) |=> !status[3]);
  // R9
  test_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !mask[4]) |-> !irq_n);
  // R11
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);
endmodule

// File: tb/sim_irq_status_reg.sv
module sim_irq_status_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_recov_done = 0, ev_sensor = 0, recov_req = 0, ev_bus_lost = 0;
  logic       ext_irq_n = 1, test_self = 0, test_other = 0;
  logic [5:0] mask = '0;
  logic       rd_start = 0, scl_pulse = 0;
  logic [7:0] status;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  irq_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .ev_recov_done(ev_recov_done), .ev_sensor(ev_sensor),
    .recov_req(recov_req), .ev_bus_lost(ev_bus_lost), .ext_irq_n(ext_irq_n),
    .test_self(test_self), .test_other(test_other), .mask(mask),
    .rd_start(rd_start), .scl_pulse(scl_pulse), .status(status), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic exp_irq(logic [7:0] st, logic [5:0] m);
    return ((st[5:0] & ~m) == 6'd0);
  endfunction

  task automatic start_read();
    rd_start = 1; tick(); rd_start = 0;
  endtask

  task automatic one_pulse();
    scl_pulse = 1; tick(); scl_pulse = 0; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1", status, 8'h00);
    chk("R1", {7'd0, irq_n}, 8'h01);
    rst_n = 1; tick();
    chk("R1", status, 8'h00);

    // R9 sweep over every flag and every mask, with R2/R3/R4/R5/R7/R8/R11
    for (int b = 0; b < 6; b++) begin
      for (int m = 0; m < 64; m++) begin
        mask = 6'(m);
        case (b)
          0: ext_irq_n = 0;
          1: ev_recov_done = 1;
          2: ev_sensor = 1;
          3: ev_bus_lost = 1;
          4: test_self = 1;
          default: test_other = 1;
        endcase
        tick();
        ev_recov_done = 0; ev_sensor = 0; ev_bus_lost = 0;
        chk($sformatf("R%0d", (b == 0) ? 2 : (b == 4) ? 7 : (b == 5) ? 8 : b + 2),
            status, 8'(1 << b));
        chk("R9", {7'd0, irq_n}, {7'd0, exp_irq(8'(1 << b), 6'(m))});
        chk("R11", {6'd0, status[7:6]}, 8'h00);
        ext_irq_n = 1; test_self = 0; test_other = 0;
        start_read(); one_pulse(); one_pulse();
        chk("R6", status, 8'h00);
      end
    end
    mask = '0;

    // R6: first pulse keeps, second clears
    ev_recov_done = 1; ev_sensor = 1; ev_bus_lost = 1; tick();
    ev_recov_done = 0; ev_sensor = 0; ev_bus_lost = 0;
    chk("R6", status, 8'h0E);
    one_pulse();
    chk("R6 no read active", status, 8'h0E);
    start_read();
    chk("R6", status, 8'h0E);
    one_pulse();
    chk("R6 first pulse", status, 8'h0E);
    scl_pulse = 1; tick(); scl_pulse = 0;
    chk("R6 second pulse", status, 8'h00);
    ev_bus_lost = 1; tick(); ev_bus_lost = 0;
    one_pulse(); one_pulse();
    chk("R6 extra pulses", status, 8'h08);
    start_read(); one_pulse(); one_pulse();
    chk("R6", status, 8'h00);

    // R4 suppression
    recov_req = 1; ev_sensor = 1; tick(); ev_sensor = 0; recov_req = 0;
    chk("R4 suppressed", status, 8'h00);
    chk("R4 irq", {7'd0, irq_n}, 8'h01);

    // R10 set wins
    start_read(); one_pulse();
    scl_pulse = 1; ev_bus_lost = 1; ev_recov_done = 1; tick();
    scl_pulse = 0; ev_bus_lost = 0; ev_recov_done = 0;
    chk("R10", status, 8'h0A);
    start_read(); one_pulse(); one_pulse();
    chk("R10", status, 8'h00);

    // R2/R7/R8 reads do not clear; R12 re-raise
    ext_irq_n = 0; test_self = 1; test_other = 1; tick();
    chk("R2 R7 R8", status, 8'h31);
    start_read(); one_pulse(); one_pulse(); one_pulse();
    chk("R2 R7 R8 after read", status, 8'h31);
    mask = 6'h30;
    chk("R12", {7'd0, irq_n}, 8'h00);
    test_self = 0; tick();
    chk("R7 clear", status, 8'h21);
    test_other = 0; tick();
    chk("R8 clear", status, 8'h01);
    ext_irq_n = 1; tick();
    chk("R2 clear", status, 8'h00);
    chk("R9", {7'd0, irq_n}, 8'h01);

    // R1 reset mid-operation
    ev_bus_lost = 1; test_self = 1; tick(); ev_bus_lost = 0;
    rst_n = 0; #1;
    chk("R1", status, 8'h00);
    test_self = 0; tick(); rst_n = 1; tick();
    chk("R1", status, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule